// File: doc/BRIEF.md
# Late-Write Burst SRAM with Write Bypass

This block is a synchronous, pipelined static memory built from registers. Its depth and word width are set by parameters. Each clock cycle may carry one access. A load strobe opens a new access at an external address. A burst strobe continues the open burst at its next address. A mode input, taken with the load, decides whether every access moves one word (single rate) or two words (double rate). In double rate the two words travel side by side on a data path that is twice the word width. Another input taken with the load chooses linear or interleaved ordering for the two low address bits.

Writes follow a late-write scheme. The data for a write access is presented one cycle after its address. The address waits in a first stage, and when the data arrives the pair moves into a posted write buffer. The buffered entry is written into the array when the next write's data arrives. Every read compares its address with the buffered entry, so it returns the newest data even when that data has not reached the array yet. Read data leaves through an output register two clocks after the address cycle. An echo output toggles each time that register takes a new result. An asynchronous output enable forces the data outputs to zero at once, without waiting for a clock.

The burst sequencer has two states. S_IDLE means no burst is open. S_OPEN means the current burst still has beats left. A load moves the sequencer from S_IDLE to S_OPEN, and a load in S_OPEN restarts the burst and stays in S_OPEN. A burst strobe in S_OPEN stays in S_OPEN while beats remain after it, and returns to S_IDLE when it uses the last beat. Idle cycles never change the state.

Top module: `lwb_sram`

## Requirements
- R1: After reset every array word reads as zero, `rdata_o` is zero and `echo_o` is 0.
- R2: When `ld_i` is 1 on a rising edge, the block samples `addr_i`, `wr_i`, `ddr_i` and `il_i` and starts a new burst at beat 0. This overrides `bst_i` and any burst already open.
- R3: In linear order (`il_i`=0 at the load), the two low address bits of beat k are (start + k) mod 4. The upper address bits stay those of the load.
- R4: In interleaved order (`il_i`=1 at the load), the two low address bits of beat k are start XOR k.
- R5: A burst holds at most 4 words. In single rate each `bst_i` advances the burst by one beat, and in double rate by two. `bst_i` when no burst is open, or when the burst has used all 4 words, causes no access. Idle cycles (both strobes 0) do not close a burst.
- R6: A double-rate access moves two words. Lane 0 (`[DW-1:0]`) carries beat k and lane 1 (`[2*DW-1:DW]`) carries beat k+1, and the two are always different addresses. In a single-rate access, write lane 1 is ignored and read lane 1 returns zero.
- R7: The data of a write access is taken from `wdata_i` on the rising edge one cycle after the access edge. `wdata_i` on the access edge itself has no effect.
- R8: Read data appears in the output register after the second rising edge following the access edge. The register holds its value until the next read result arrives.
- R9: A read returns the newest data written to its address, including a write whose data is still in the posted buffer. This holds even when the read access comes in the very cycle after the write access.
- R10: `echo_o` toggles exactly once for each read result loaded into the output register and is otherwise stable.
- R11: While `oe_i` is 0, `rdata_o` is zero at once, with no clock edge needed. When `oe_i` returns to 1, the held read data reappears at once.
- R12: When several writes target one address, a later read returns the data of the latest write issued before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, applied synchronously |
| ld_i | input | 1 | Start a new access at `addr_i` |
| bst_i | input | 1 | Advance the open burst |
| wr_i | input | 1 | Burst direction, taken with `ld_i`: 1 write, 0 read |
| ddr_i | input | 1 | Transfer mode, taken with `ld_i`: 1 double rate |
| il_i | input | 1 | Burst order, taken with `ld_i`: 1 interleaved |
| addr_i | input | AW | Word address |
| wdata_i | input | 2*DW | Late write data, lane 0 low and lane 1 high |
| oe_i | input | 1 | Asynchronous output enable |
| rdata_o | output | 2*DW | Registered read data, forced to zero while `oe_i` is 0 |
| echo_o | output | 1 | Toggles on every new read result |

## Verification
The risky overlap is the late data of a write arriving on the same edge that samples the address of a read to that word. In that one cycle the write pipeline moves its entry into the buffer while the read pipeline captures the address that must later hit on that buffer. The bench provokes this with directed write-then-read pairs and also through random streams confined to sixteen addresses, where such pairs occur often. Every result is judged against a bench memory that applies each write in issue order, so any result taken from the stale array shows up as a miscompare.

// File: rtl/lwb_pkg.sv
`timescale 1ns/1ps
package lwb_pkg;
    localparam int LANES = 2;
    localparam int BEATS = 4;

    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_OPEN = 1'b1
    } seq_state_e;

    // Low address bits of beat k within a four-word burst
    function automatic logic [1:0] beat_offset(input logic [1:0] start,
                                               input logic [1:0] k,
                                               input logic       interleave);
        return interleave ? (start ^ k) : (start + k);
    endfunction
endpackage

// File: rtl/lwb_burst_seq.sv
`timescale 1ns/1ps
module lwb_burst_seq
    import lwb_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ld,
    input  logic                        bst,
    input  logic                        wr,
    input  logic                        ddr,
    input  logic                        il,
    input  logic [AW-1:0]               addr,
    output logic                        acc_valid,
    output logic                        acc_wr,
    output logic                        acc_ddr,
    output logic [LANES-1:0][AW-1:0]    acc_addr
);
    localparam int HW = AW - 2;
    localparam int CW = $clog2(BEATS) + 1;

    seq_state_e    state_q, state_d;
    logic [HW-1:0] hi_q, hi_d;
    logic [1:0]    start_q, start_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          wr_q, wr_d, ddr_q, ddr_d, il_q, il_d;
    logic          start_new, cont;
    logic [1:0]    beat;
    logic [CW-1:0] step;

    // Transition decode
    always_comb begin
        start_new = 1'b0;
        cont      = 1'b0;
        unique case (state_q)
            S_IDLE: start_new = ld;
            S_OPEN: begin
                start_new = ld;
                cont      = !ld && bst;
            end
            default: ;
        endcase
    end

    // Next state and access outputs
    always_comb begin
        hi_d    = hi_q;
        start_d = start_q;
        wr_d    = wr_q;
        ddr_d   = ddr_q;
        il_d    = il_q;
        cnt_d   = cnt_q;
        beat    = cnt_q[1:0];
        if (start_new) begin
            hi_d    = addr[AW-1:2];
            start_d = addr[1:0];
            wr_d    = wr;
            ddr_d   = ddr;
            il_d    = il;
            beat    = 2'd0;
        end
        step = ddr_d ? CW'(2) : CW'(1);
        if (start_new) begin
            cnt_d = step;
        end else if (cont) begin
            cnt_d = cnt_q + step;
        end
        state_d = state_q;
        if (start_new || cont) begin
            state_d = (cnt_d >= CW'(BEATS)) ? S_IDLE : S_OPEN;
        end
        acc_valid = start_new || cont;
        acc_wr    = wr_d;
        acc_ddr   = ddr_d;
        for (int l = 0; l < LANES; l++) begin
            acc_addr[l] = {hi_d, beat_offset(start_d, beat + 2'(l), il_d)};
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            hi_q    <= '0;
            start_q <= '0;
            cnt_q   <= '0;
            wr_q    <= 1'b0;
            ddr_q   <= 1'b0;
            il_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            hi_q    <= hi_d;
            start_q <= start_d;
            cnt_q   <= cnt_d;
            wr_q    <= wr_d;
            ddr_q   <= ddr_d;
            il_q    <= il_d;
        end
    end

    AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !ld) |-> !acc_valid); // R5
    AST_LOAD_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (state_q == S_OPEN)); // R2
    AST_DDR_TAIL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !ld && acc_ddr) |=> (state_q == S_IDLE)); // R5
endmodule

// File: rtl/lwb_write_pipe.sv
`timescale 1ns/1ps
module lwb_write_pipe
    import lwb_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_valid,
    input  logic                        wr_ddr,
    input  logic [LANES-1:0][AW-1:0]    wr_addr,
    input  logic [LANES-1:0][DW-1:0]    wdata,
    output logic [LANES-1:0]            buf_valid,
    output logic [LANES-1:0][AW-1:0]    buf_addr,
    output logic [LANES-1:0][DW-1:0]    buf_data,
    output logic [LANES-1:0]            commit_en
);
    // Stage 1: address waiting for its late data
    logic                     a1_valid;
    logic                     a1_ddr;
    logic [LANES-1:0][AW-1:0] a1_addr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a1_valid  <= 1'b0;
            a1_ddr    <= 1'b0;
            a1_addr   <= '0;
            buf_valid <= '0;
            buf_addr  <= '0;
            buf_data  <= '0;
        end else begin
            a1_valid <= wr_valid;
            a1_ddr   <= wr_ddr;
            a1_addr  <= wr_addr;
            // Stage 2: data arrives, entry becomes the posted buffer
            if (a1_valid) begin
                buf_addr <= a1_addr;
                buf_data <= wdata;
                for (int l = 0; l < LANES; l++) begin
                    buf_valid[l] <= (l == 0) ? 1'b1 : a1_ddr;
                end
            end
        end
    end

    // Older entry drains to the array when a newer one arrives
    for (genvar g = 0; g < LANES; g++) begin : g_commit
        assign commit_en[g] = a1_valid & buf_valid[g];
    end

    AST_LATE_DATA_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        a1_valid |=> (buf_data == $past(wdata))); // R7
    AST_ADDR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        a1_valid |=> (buf_addr == $past(a1_addr))); // R9
endmodule

// File: rtl/lwb_store.sv
`timescale 1ns/1ps
module lwb_store
    import lwb_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [LANES-1:0]            commit_en,
    input  logic [LANES-1:0][AW-1:0]    commit_addr,
    input  logic [LANES-1:0][DW-1:0]    commit_data,
    input  logic [LANES-1:0][AW-1:0]    rd_addr,
    output logic [LANES-1:0][DW-1:0]    rd_word
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int l = 0; l < LANES; l++) begin
                if (commit_en[l]) begin
                    mem_q[commit_addr[l]] <= commit_data[l];
                end
            end
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_rd
        assign rd_word[g] = mem_q[rd_addr[g]];
    end

    AST_LANES_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_en[0] && commit_en[1]) |-> (commit_addr[0] != commit_addr[1])); // R6
endmodule

// File: rtl/lwb_read_pipe.sv
`timescale 1ns/1ps
module lwb_read_pipe
    import lwb_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd_valid,
    input  logic                        rd_ddr,
    input  logic [LANES-1:0][AW-1:0]    rd_addr,
    input  logic [LANES-1:0][DW-1:0]    mem_word,
    input  logic [LANES-1:0]            buf_valid,
    input  logic [LANES-1:0][AW-1:0]    buf_addr,
    input  logic [LANES-1:0][DW-1:0]    buf_data,
    output logic [LANES-1:0][AW-1:0]    look_addr,
    output logic [LANES-1:0][DW-1:0]    q,
    output logic                        echo
);
    logic                     r1_valid, r1_ddr;
    logic [LANES-1:0][AW-1:0] r1_addr;
    logic                     r2_valid, r2_ddr;
    logic [LANES-1:0][DW-1:0] r2_word;
    logic [LANES-1:0][DW-1:0] hit_word;

    assign look_addr = r1_addr;

    // Address comparator: posted entry wins over the array
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            hit_word[l] = mem_word[l];
            for (int b = 0; b < LANES; b++) begin
                if (buf_valid[b] && (buf_addr[b] == r1_addr[l])) begin
                    hit_word[l] = buf_data[b];
                end
            end
            if (l != 0 && !r1_ddr) begin
                hit_word[l] = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r1_valid <= 1'b0;
            r1_ddr   <= 1'b0;
            r1_addr  <= '0;
            r2_valid <= 1'b0;
            r2_ddr   <= 1'b0;
            r2_word  <= '0;
            q        <= '0;
            echo     <= 1'b0;
        end else begin
            r1_valid <= rd_valid;
            r1_ddr   <= rd_ddr;
            r1_addr  <= rd_addr;
            r2_valid <= r1_valid;
            r2_ddr   <= r1_ddr;
            if (r1_valid) begin
                r2_word <= hit_word;
            end
            if (r2_valid) begin
                q    <= r2_word;
                echo <= ~echo;
            end
        end
    end

    AST_ECHO_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        r2_valid |=> (echo != $past(echo))); // R10
    AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !r2_valid |=> ($stable(q) && $stable(echo))); // R8
    AST_SDR_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (r2_valid && !r2_ddr) |=> (q[LANES-1] == '0)); // R6
endmodule

// File: rtl/lwb_sram.sv
`timescale 1ns/1ps
module lwb_sram
    import lwb_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ld_i,
    input  logic                  bst_i,
    input  logic                  wr_i,
    input  logic                  ddr_i,
    input  logic                  il_i,
    input  logic [AW-1:0]         addr_i,
    input  logic [LANES*DW-1:0]   wdata_i,
    input  logic                  oe_i,
    output logic [LANES*DW-1:0]   rdata_o,
    output logic                  echo_o
);
    logic                     acc_valid, acc_wr, acc_ddr;
    logic [LANES-1:0][AW-1:0] acc_addr;
    logic [LANES-1:0][DW-1:0] wdata_l, q_l, mem_word;
    logic [LANES-1:0]         buf_valid, commit_en;
    logic [LANES-1:0][AW-1:0] buf_addr, look_addr;
    logic [LANES-1:0][DW-1:0] buf_data;

    assign wdata_l = wdata_i;

    lwb_burst_seq #(.AW(AW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld        (ld_i),
        .bst       (bst_i),
        .wr        (wr_i),
        .ddr       (ddr_i),
        .il        (il_i),
        .addr      (addr_i),
        .acc_valid (acc_valid),
        .acc_wr    (acc_wr),
        .acc_ddr   (acc_ddr),
        .acc_addr  (acc_addr)
    );

    lwb_write_pipe #(.AW(AW), .DW(DW)) u_wpipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (acc_valid & acc_wr),
        .wr_ddr    (acc_ddr),
        .wr_addr   (acc_addr),
        .wdata     (wdata_l),
        .buf_valid (buf_valid),
        .buf_addr  (buf_addr),
        .buf_data  (buf_data),
        .commit_en (commit_en)
    );

    lwb_store #(.AW(AW), .DW(DW)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit_en   (commit_en),
        .commit_addr (buf_addr),
        .commit_data (buf_data),
        .rd_addr     (look_addr),
        .rd_word     (mem_word)
    );

    lwb_read_pipe #(.AW(AW), .DW(DW)) u_rpipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_valid  (acc_valid & ~acc_wr),
        .rd_ddr    (acc_ddr),
        .rd_addr   (acc_addr),
        .mem_word  (mem_word),
        .buf_valid (buf_valid),
        .buf_addr  (buf_addr),
        .buf_data  (buf_data),
        .look_addr (look_addr),
        .q         (q_l),
        .echo      (echo_o)
    );

    // Asynchronous output enable
    assign rdata_o = oe_i ? q_l : '0;
endmodule

// File: tb/test_lwb_sram.sv
`timescale 1ns/1ps
module test_lwb_sram;
    import lwb_pkg::*;
    localparam int AW = 6;
    localparam int DW = 16;
    localparam int WW = LANES * DW;
    localparam int RAND_CYCLES = 3000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ld_i, bst_i, wr_i, ddr_i, il_i, oe_i;
    logic [AW-1:0] addr_i;
    logic [WW-1:0] wdata_i, rdata_o;
    logic          echo_o;

    always #2 clk = ~clk;

    lwb_sram #(.AW(AW), .DW(DW)) i_lwb_sram (
        .clk(clk), .rst_n(rst_n), .ld_i(ld_i), .bst_i(bst_i), .wr_i(wr_i),
        .ddr_i(ddr_i), .il_i(il_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .oe_i(oe_i), .rdata_o(rdata_o), .echo_o(echo_o)
    );

    int n_vec = 0;
    int n_bad = 0;
    int it = 0;
    logic [DW-1:0]   mdl [1 << AW];
    bit              b_open, b_wr, b_ddr, b_il;
    logic [AW-3:0]   b_hi;
    logic [1:0]      b_st;
    int              b_k;
    bit              ev [4];
    logic [WW-1:0]   ed [4];
    string           et [4];
    logic [WW-1:0]   exp_q;
    bit              exp_echo;
    bit              pw;
    logic [WW-1:0]   pwd;

    function automatic logic [1:0] order(input logic [1:0] s, input int k, input bit il);
        logic [1:0] kk = 2'(k);
        return il ? (s ^ kk) : (s + kk);
    endfunction

    task automatic check(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock of stimulus; results of reads from three calls back are checked first
    task automatic cycle(input bit ld, input bit bst, input bit wr, input bit ddr, input bit il,
                         input logic [AW-1:0] a, input logic [WW-1:0] wd, input bit oe,
                         input string tag);
        int slot;
        bit acc;
        logic [AW-1:0] a0, a1;
        @(negedge clk);
        slot = (it + 1) % 4;
        if (ev[slot]) begin
            exp_q    = ed[slot];
            exp_echo = ~exp_echo;
        end
        check({et[slot], oe_i ? "" : "/R11"}, rdata_o, oe_i ? exp_q : '0);
        check({et[slot], "/R10"}, WW'(echo_o), WW'(exp_echo));
        ev[slot] = 1'b0;
        wdata_i = pw ? pwd : {$urandom, $urandom};
        pw = 1'b0;
        acc = 1'b0;
        if (ld) begin
            b_open = 1'b1; b_hi = a[AW-1:2]; b_st = a[1:0]; b_k = 0;
            b_wr = wr; b_ddr = ddr; b_il = il; acc = 1'b1;
        end else if (bst && b_open) begin
            acc = 1'b1;
        end
        if (acc) begin
            a0 = {b_hi, order(b_st, b_k, b_il)};
            a1 = {b_hi, order(b_st, b_k + 1, b_il)};
            if (b_wr) begin
                mdl[a0] = wd[DW-1:0];
                if (b_ddr) mdl[a1] = wd[WW-1:DW];
                pw = 1'b1;
                pwd = wd;
            end else begin
                ed[it % 4] = {b_ddr ? mdl[a1] : {DW{1'b0}}, mdl[a0]};
                ev[it % 4] = 1'b1;
            end
            b_k += b_ddr ? 2 : 1;
            if (b_k >= 4) b_open = 1'b0;
        end
        et[it % 4] = tag;
        ld_i = ld; bst_i = bst; wr_i = wr; ddr_i = ddr; il_i = il; addr_i = a; oe_i = oe;
        it++;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cycle(0, 0, 0, 0, 0, '0, '0, 1, tag);
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL R8 watchdog: actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0; ld_i = 0; bst_i = 0; wr_i = 0; ddr_i = 0; il_i = 0;
        addr_i = '0; wdata_i = '0; oe_i = 1'b1;
        for (int i = 0; i < (1 << AW); i++) mdl[i] = '0;
        for (int i = 0; i < 4; i++) begin ev[i] = 0; ed[i] = '0; et[i] = "R1"; end
        exp_q = '0; exp_echo = 0; pw = 0; b_open = 0; b_k = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        check("R1", rdata_o, '0);
        check("R1", WW'(echo_o), '0);

        // R5: burst strobe with nothing open
        cycle(0, 1, 0, 0, 0, 6'd3, '0, 1, "R5");
        // R7/R3: single-rate linear write from 6 -> 6,7,4,5
        cycle(1, 0, 1, 0, 0, 6'd6, 32'h0000_1111, 1, "R7");
        cycle(0, 1, 0, 0, 0, '0,  32'h0000_2222, 1, "R3");
        cycle(0, 1, 0, 0, 0, '0,  32'h0000_3333, 1, "R3");
        cycle(0, 1, 0, 0, 0, '0,  32'h0000_4444, 1, "R3");
        // R5: fifth beat must be ignored
        cycle(0, 1, 0, 0, 0, '0,  32'h0000_5555, 1, "R5");
        // R3: linear read from 4
        cycle(1, 0, 0, 0, 0, 6'd4, '0, 1, "R3");
        cycle(0, 1, 0, 0, 0, '0, '0, 1, "R3");
        idle(1, "R5");
        cycle(0, 1, 0, 0, 0, '0, '0, 1, "R5");
        cycle(0, 1, 0, 0, 0, '0, '0, 1, "R3");
        // R4: interleaved read from 7 -> 7,6,5,4
        cycle(1, 0, 0, 0, 1, 6'd7, '0, 1, "R4");
        cycle(0, 1, 0, 0, 0, '0, '0, 1, "R4");
        cycle(0, 1, 0, 0, 0, '0, '0, 1, "R4");
        cycle(0, 1, 0, 0, 0, '0, '0, 1, "R4");
        idle(3, "R8");
        // R1: untouched word
        cycle(1, 0, 0, 0, 0, 6'd60, '0, 1, "R1");
        // R6: double-rate writes and reads
        cycle(1, 0, 1, 1, 0, 6'd9, 32'hBBBB_AAAA, 1, "R6");
        cycle(0, 1, 0, 0, 0, '0, 32'hDDDD_CCCC, 1, "R6");
        cycle(0, 1, 0, 0, 0, '0, 32'hFFFF_EEEE, 1, "R5");
        cycle(1, 0, 0, 1, 1, 6'd10, '0, 1, "R6");
        cycle(0, 1, 0, 0, 0, '0, '0, 1, "R6");
        cycle(1, 0, 0, 0, 0, 6'd9, '0, 1, "R6");
        cycle(1, 0, 1, 0, 0, 6'd12, 32'h1234_9999, 1, "R6");
        idle(1, "R6");
        cycle(1, 0, 0, 1, 0, 6'd12, '0, 1, "R6");
        // R9: read right after write, buffered and committed cases
        cycle(1, 0, 1, 0, 0, 6'd20, 32'h0000_0A0A, 1, "R9");
        cycle(1, 0, 0, 0, 0, 6'd20, '0, 1, "R9");
        cycle(1, 0, 1, 0, 0, 6'd21, 32'h0000_2121, 1, "R9");
        cycle(1, 0, 1, 0, 0, 6'd22, 32'h0000_2222, 1, "R9");
        cycle(1, 0, 0, 0, 0, 6'd21, '0, 1, "R9");
        cycle(1, 0, 0, 0, 0, 6'd22, '0, 1, "R9");
        // R12: repeated writes to one word
        cycle(1, 0, 1, 0, 0, 6'd30, 32'h0000_D001, 1, "R12");
        cycle(1, 0, 1, 0, 0, 6'd30, 32'h0000_D002, 1, "R12");
        cycle(1, 0, 0, 0, 0, 6'd30, '0, 1, "R12");
        cycle(1, 0, 1, 0, 0, 6'd31, 32'h0000_E001, 1, "R12");
        idle(2, "R12");
        cycle(1, 0, 1, 0, 0, 6'd31, 32'h0000_E002, 1, "R12");
        idle(1, "R12");
        cycle(1, 0, 0, 0, 0, 6'd31, '0, 1, "R12");
        // R2: reload mid-burst restarts at new address
        cycle(1, 0, 0, 0, 0, 6'd4, '0, 1, "R2");
        cycle(1, 1, 0, 0, 0, 6'd7, '0, 1, "R2");
        cycle(0, 1, 0, 0, 0, '0, '0, 1, "R2");
        // R7: data on the access edge is ignored, next edge's data used
        cycle(1, 0, 1, 0, 0, 6'd41, 32'h0000_4141, 1, "R7");
        idle(1, "R7");
        cycle(1, 0, 0, 0, 0, 6'd41, '0, 1, "R7");
        idle(4, "R8");
        // R11: asynchronous output enable between edges
        @(posedge clk);
        #1 oe_i = 1'b0;
        #0.5 check("R11", rdata_o, '0);
        oe_i = 1'b1;
        #0.3 check("R11", rdata_o, exp_q);

        // R8: random traffic over sixteen words
        for (int n = 0; n < RAND_CYCLES; n++) begin
            int r = $urandom % 100;
            logic [AW-1:0] ra;
            ra = {AW'($urandom % 4) , 2'($urandom)} ;
            ra = {ra[AW-1:2] & (AW-2)'(3), ra[1:0]};
            cycle(r < 35, (r >= 35) && (r < 75), 1'($urandom), 1'($urandom), 1'($urandom),
                  ra, {$urandom, $urandom}, ($urandom % 10) != 0, "R8");
        end
        idle(4, "R8");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule